// File: doc/BRIEF.md
# Black-Level Offset Calibration Servo

This block closes a digital servo loop around an image sensor's analog front end during the dark reference pixels that begin each line. While the dark-window flag is high it counts valid ADC samples in groups and, at the end of every group, compares the last sample of the group with a programmed black-level target. It then nudges a 9-bit offset DAC code by one step toward the target. The DAC code is the block's only lasting state. It carries over from window to window, line to line and frame to frame, so a loop that starts far off converges slowly over many lines.

The first group in each dark window is eight valid pixels long. Every later group in the same window is six pixels long. A 20-pixel window therefore makes exactly three decisions. The 8-bit target is compared as an unsigned 10-bit value with its upper two bits zero. Each decision raises a one-cycle pulse, including a decision that finds the sample already on target and leaves the code alone.

Top module: `cal_offset_servo`

## Requirements
- R1: During and straight after reset, `dac_code` is mid-scale (256 for 9 bits) and `adj_pulse` is 0.
- R2: A pixel counts only when `blk_win` and `smp_vld` are both 1. While `blk_win` is 0, `dac_code` does not change and no pulse is raised, whatever `smp_vld` and `smp_code` do.
- R3: In each window the first decision falls on the 8th valid pixel, and each later decision falls on every further 6th valid pixel (a 20-pixel window gives pixels 8, 14 and 20). `adj_pulse` is 1 for exactly the one cycle after the clock edge that samples the deciding pixel, and `dac_code` updates on that same edge. At no other time does `dac_code` change.
- R4: At a decision, if the deciding sample is below the widened target, `dac_code` rises by exactly 1. If the sample is above the widened target, `dac_code` falls by exactly 1.
- R5: At a decision where the sample equals the widened target, `dac_code` is unchanged, but `adj_pulse` still fires.
- R6: The target is widened as `{2'b00, tgt_lvl}`. For example, a sample of 0x100 against a target of 0xFF counts as above the target.
- R7: Only the code of the group's last valid pixel decides the step. The other pixels of the group have no effect on it.
- R8: `dac_code` saturates at 0 and at 511 and never wraps. The loop keeps stepping over at least 264 consecutive decisions.
- R9: An unfinished group is discarded when `blk_win` falls. Each new window starts counting from zero, again with the 8-pixel first group.
- R10: A new `tgt_lvl` is used from the next decision onward. Changing it does not alter `dac_code` by itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | ADC sample valid strobe |
| smp_code | input | 10 | ADC sample code |
| blk_win | input | 1 | Dark reference pixel window flag |
| tgt_lvl | input | 8 | Programmed black-level target |
| dac_code | output | 9 | Offset-adjust DAC control code |
| adj_pulse | output | 1 | One-cycle pulse per adjustment decision |

## Verification
The hardest states to reach from the ports are the two saturation rails. From mid-scale, the loop needs hundreds of decisions, and each decision costs six pixels. The bench drives single very long dark windows with the sample pinned at one extreme and the target at the other, so that 300 and then 600 decisions run back to back. It then confirms that the code stops at 511 and at 0 and does not wrap. Group boundaries that straddle window edges and gaps in the valid strobe are driven as separate short patterns, and the bench tracks the exact pixel index at which each pulse is expected.

// File: rtl/cal_servo_pkg.sv
package cal_servo_pkg;

    // Direction chosen at an adjustment decision
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_dir_e;

endpackage

// File: rtl/cal_grp_pacer.sv
// Counts qualified pixels inside the dark window and flags the last pixel
// of each decision group (long first group, shorter later groups).
module cal_grp_pacer #(
    parameter int FIRST_LEN = 8,
    parameter int NEXT_LEN  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blk_win,
    input  logic smp_vld,
    output logic grp_done
);

    localparam int MAX_LEN = (FIRST_LEN > NEXT_LEN) ? FIRST_LEN : NEXT_LEN;
    localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
    localparam logic [CNT_W-1:0] FIRST_LAST = CNT_W'(FIRST_LEN - 1);
    localparam logic [CNT_W-1:0] NEXT_LAST  = CNT_W'(NEXT_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             first;
    } pacer_st_t;

    pacer_st_t st_q, st_d;
    logic      pix_ok;
    logic [CNT_W-1:0] last_idx;

    always_comb begin
        st_d     = st_q;
        pix_ok   = blk_win && smp_vld;
        last_idx = st_q.first ? FIRST_LAST : NEXT_LAST;
        grp_done = pix_ok && (st_q.cnt == last_idx);

        if (!blk_win) begin
            // window closed: drop any unfinished group, rearm long group
            st_d.cnt   = '0;
            st_d.first = 1'b1;
        end else if (pix_ok) begin
            if (grp_done) begin
                st_d.cnt   = '0;
                st_d.first = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.first <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cal_dir_decide.sv
// Compares a sample with the zero-widened target and picks a step direction.
module cal_dir_decide
    import cal_servo_pkg::*;
#(
    parameter int ADC_W = 10,
    parameter int TGT_W = 8
) (
    input  logic [ADC_W-1:0] smp_code,
    input  logic [TGT_W-1:0] tgt_lvl,
    output step_dir_e        dir
);

    logic [ADC_W-1:0] tgt_wide;

    generate
        if (ADC_W > TGT_W) begin : g_widen
            assign tgt_wide = {{(ADC_W - TGT_W){1'b0}}, tgt_lvl};
        end else begin : g_same
            assign tgt_wide = tgt_lvl[ADC_W-1:0];
        end
    endgenerate

    always_comb begin
        if (smp_code < tgt_wide) begin
            dir = STEP_UP;
        end else if (smp_code > tgt_wide) begin
            dir = STEP_DOWN;
        end else begin
            dir = STEP_HOLD;
        end
    end

endmodule

// File: rtl/cal_dac_accum.sv
// Holds the offset DAC code and applies saturating single-step moves.
module cal_dac_accum
    import cal_servo_pkg::*;
#(
    parameter int DAC_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grp_done,
    input  step_dir_e        dir,
    output logic [DAC_W-1:0] dac_code,
    output logic             adj_pulse
);

    localparam logic [DAC_W-1:0] DAC_MID = DAC_W'(1) << (DAC_W - 1);
    localparam logic [DAC_W-1:0] DAC_TOP = {DAC_W{1'b1}};

    typedef struct packed {
        logic [DAC_W-1:0] dac;
        logic             pulse;
    } accum_st_t;

    accum_st_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = grp_done;
        if (grp_done) begin
            case (dir)
                STEP_UP:   if (st_q.dac != DAC_TOP) st_d.dac = st_q.dac + DAC_W'(1);
                STEP_DOWN: if (st_q.dac != '0)      st_d.dac = st_q.dac - DAC_W'(1);
                default:   st_d.dac = st_q.dac;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dac   <= DAC_MID;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_code  = st_q.dac;
    assign adj_pulse = st_q.pulse;

endmodule

// File: rtl/cal_offset_servo.sv
// Black-level offset calibration servo: top level.
module cal_offset_servo
    import cal_servo_pkg::*;
#(
    parameter int ADC_W     = 10,
    parameter int TGT_W     = 8,
    parameter int DAC_W     = 9,
    parameter int FIRST_LEN = 8,
    parameter int NEXT_LEN  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [ADC_W-1:0] smp_code,
    input  logic             blk_win,
    input  logic [TGT_W-1:0] tgt_lvl,
    output logic [DAC_W-1:0] dac_code,
    output logic             adj_pulse
);

    logic      grp_done;
    step_dir_e dir;

    cal_grp_pacer #(
        .FIRST_LEN (FIRST_LEN),
        .NEXT_LEN  (NEXT_LEN)
    ) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_win  (blk_win),
        .smp_vld  (smp_vld),
        .grp_done (grp_done)
    );

    cal_dir_decide #(
        .ADC_W (ADC_W),
        .TGT_W (TGT_W)
    ) u_decide (
        .smp_code (smp_code),
        .tgt_lvl  (tgt_lvl),
        .dir      (dir)
    );

    cal_dac_accum #(
        .DAC_W (DAC_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .grp_done  (grp_done),
        .dir       (dir),
        .dac_code  (dac_code),
        .adj_pulse (adj_pulse)
    );

endmodule

// File: rtl/cal_servo_chk.sv
// Property checker bound to the calibration servo top.
module cal_servo_chk #(
    parameter int ADC_W = 10,
    parameter int TGT_W = 8,
    parameter int DAC_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_vld,
    input logic [ADC_W-1:0] smp_code,
    input logic             blk_win,
    input logic [TGT_W-1:0] tgt_lvl,
    input logic [DAC_W-1:0] dac_code,
    input logic             adj_pulse
);

    localparam logic [DAC_W-1:0] DAC_TOP = {DAC_W{1'b1}};

    logic [ADC_W-1:0] tgt_ext;
    assign tgt_ext = ADC_W'(tgt_lvl);

    // R2
    hold_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_win |=> $stable(dac_code));

    // R2
    pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adj_pulse |-> $past(blk_win && smp_vld));

    // R3
    pulse_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adj_pulse |=> !adj_pulse);

    // R3
    quiet_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adj_pulse |-> $stable(dac_code));

    // R4
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_pulse && $past(smp_code < tgt_ext) && ($past(dac_code) != DAC_TOP))
        |-> (dac_code == $past(dac_code) + DAC_W'(1)));

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_pulse && $past(smp_code > tgt_ext) && ($past(dac_code) != '0))
        |-> (dac_code == $past(dac_code) - DAC_W'(1)));

    // R5
    equal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_pulse && $past(smp_code == tgt_ext)) |-> $stable(dac_code));

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(($past(dac_code) == DAC_TOP && dac_code == '0) ||
          ($past(dac_code) == '0 && dac_code == DAC_TOP)));

endmodule

bind cal_offset_servo cal_servo_chk #(
    .ADC_W (ADC_W),
    .TGT_W (TGT_W),
    .DAC_W (DAC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .smp_code  (smp_code),
    .blk_win   (blk_win),
    .tgt_lvl   (tgt_lvl),
    .dac_code  (dac_code),
    .adj_pulse (adj_pulse)
);

// File: tb/cal_offset_servo_tb.sv
module cal_offset_servo_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_vld = 1'b0;
    logic [9:0] smp_code = '0;
    logic       blk_win = 1'b0;
    logic [7:0] tgt_lvl = '0;
    logic [8:0] dac_code;
    logic       adj_pulse;

    int  checks = 0;
    int  errors = 0;
    int  pulses = 0;
    bit  got_pulse;
    bit  done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_offset_servo u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_vld   (smp_vld),
        .smp_code  (smp_code),
        .blk_win   (blk_win),
        .tgt_lvl   (tgt_lvl),
        .dac_code  (dac_code),
        .adj_pulse (adj_pulse)
    );

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One pixel cycle: drive at falling edge, sample just after rising edge.
    task automatic px(input logic w, input logic v, input logic [9:0] c);
        @(negedge clk);
        blk_win  = w;
        smp_vld  = v;
        smp_code = c;
        @(posedge clk);
        #1;
        got_pulse = adj_pulse;
        if (adj_pulse) pulses++;
    endtask

    task automatic win_close();
        px(1'b0, 1'b0, 10'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; blk_win = 1'b0; smp_vld = 1'b0; smp_code = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        pulses = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk_eq("R1 dac during reset", dac_code, 256);
        chk_eq("R1 pulse during reset", adj_pulse, 0);
        do_reset();
        @(posedge clk); #1;
        chk_eq("R1 dac after reset", dac_code, 256);
        chk_eq("R1 pulse after reset", adj_pulse, 0);
    endtask

    task automatic t_twenty();
        do_reset();
        tgt_lvl = 8'h40;
        for (int i = 1; i <= 20; i++) begin
            px(1'b1, 1'b1, 10'd300);
            chk_eq($sformatf("R3 pulse at pixel %0d", i), got_pulse,
                   (i == 8 || i == 14 || i == 20) ? 1 : 0);
            if (i == 8) chk_eq("R4 down step after first group", dac_code, 255);
        end
        win_close();
        chk_eq("R3 pulses in 20-pixel window", pulses, 3);
        chk_eq("R4 dac after 20-pixel window", dac_code, 253);
    endtask

    task automatic t_outside();
        do_reset();
        tgt_lvl = 8'hFF;
        for (int i = 0; i < 30; i++) px(1'b0, 1'b1, 10'd0);
        chk_eq("R2 no pulse outside window", pulses, 0);
        chk_eq("R2 dac held outside window", dac_code, 256);
        for (int i = 0; i < 30; i++) px(1'b1, 1'b0, 10'd0);
        win_close();
        chk_eq("R2 no pulse without valid", pulses, 0);
        chk_eq("R2 dac held without valid", dac_code, 256);
    endtask

    task automatic t_partial();
        do_reset();
        tgt_lvl = 8'h40;
        for (int i = 0; i < 13; i++) px(1'b1, 1'b1, 10'd0);
        win_close();
        chk_eq("R9 one decision in 13-pixel window", pulses, 1);
        chk_eq("R9 dac after 13-pixel window", dac_code, 257);
        for (int i = 0; i < 7; i++) px(1'b1, 1'b1, 10'd0);
        win_close();
        chk_eq("R9 leftover discarded, 7-pixel window", pulses, 1);
        chk_eq("R9 dac after 7-pixel window", dac_code, 257);
        for (int i = 1; i <= 8; i++) begin
            px(1'b1, 1'b1, 10'd0);
            if (i == 6) chk_eq("R9 no six-pixel group at window start", got_pulse, 0);
        end
        win_close();
        chk_eq("R9 long first group rearmed", pulses, 2);
        chk_eq("R9 dac after 8-pixel window", dac_code, 258);
    endtask

    task automatic t_equal();
        do_reset();
        tgt_lvl = 8'h55;
        for (int i = 0; i < 14; i++) px(1'b1, 1'b1, 10'h055);
        win_close();
        chk_eq("R5 pulses on target", pulses, 2);
        chk_eq("R5 dac unchanged on target", dac_code, 256);
    endtask

    task automatic t_zero_ext();
        do_reset();
        tgt_lvl = 8'hFF;
        for (int i = 0; i < 8; i++) px(1'b1, 1'b1, 10'h100);
        win_close();
        chk_eq("R6 0x100 above widened 0xFF", dac_code, 255);
        for (int i = 0; i < 8; i++) px(1'b1, 1'b1, 10'h0FF);
        win_close();
        chk_eq("R6 0x0FF equals widened 0xFF", dac_code, 255);
    endtask

    task automatic t_last_pixel();
        do_reset();
        tgt_lvl = 8'h80;
        for (int i = 1; i <= 8; i++) px(1'b1, 1'b1, (i == 8) ? 10'h3FF : 10'h000);
        chk_eq("R7 last pixel high steps down", dac_code, 255);
        for (int i = 9; i <= 14; i++) px(1'b1, 1'b1, (i == 14) ? 10'h000 : 10'h3FF);
        win_close();
        chk_eq("R7 last pixel low steps up", dac_code, 256);
    endtask

    task automatic t_gaps();
        do_reset();
        tgt_lvl = 8'h10;
        for (int i = 1; i <= 16; i++) begin
            px(1'b1, (i % 2) == 0, 10'd0);
            chk_eq($sformatf("R2 gapped pulse at cycle %0d", i), got_pulse, (i == 16) ? 1 : 0);
        end
        win_close();
        chk_eq("R2 dac after gapped group", dac_code, 257);
    endtask

    task automatic t_target_change();
        do_reset();
        tgt_lvl = 8'h40;
        for (int i = 1; i <= 14; i++) px(1'b1, 1'b1, 10'h050);
        chk_eq("R10 dac before target change", dac_code, 254);
        @(negedge clk);
        tgt_lvl = 8'h60;
        @(posedge clk); #1;
        chk_eq("R10 target write leaves dac", dac_code, 254);
        for (int i = 15; i <= 20; i++) px(1'b1, 1'b1, 10'h050);
        win_close();
        chk_eq("R10 new target used at next decision", dac_code, 255);
    endtask

    task automatic t_saturate();
        do_reset();
        tgt_lvl = 8'hFF;
        for (int i = 0; i < 8 + 6 * 299; i++) px(1'b1, 1'b1, 10'h000);
        win_close();
        chk_eq("R8 decisions in long window", pulses, 300);
        chk_eq("R8 top rail holds", dac_code, 511);
        pulses = 0;
        tgt_lvl = 8'h00;
        for (int i = 0; i < 8 + 6 * 599; i++) px(1'b1, 1'b1, 10'h3FF);
        win_close();
        chk_eq("R8 decisions in falling window", pulses, 600);
        chk_eq("R8 bottom rail holds", dac_code, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", WATCHDOG, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_twenty();
        t_outside();
        t_partial();
        t_equal();
        t_zero_ext();
        t_last_pixel();
        t_gaps();
        t_target_change();
        t_saturate();
        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule